// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a single-issue 32-bit core fetches next. Given the address of the current instruction, the instruction word and the two source operand values read from the register file, it produces the next fetch address. It also produces a write request and a value for the return-address register (register 31). Four control-flow instructions are recognised: a register-indirect jump, a jump-and-link, a not-equal branch and a less-or-equal-zero branch. Everything else continues to the next sequential word.

The unit also supplies the two source register numbers, right-justified, so that the register file can be indexed directly. A static mode input states whether the architecture executes one instruction after a jump, known as a delay slot. That choice moves the return address one word further. The block has no clock: the caller holds the program counter in a register and loads `next_pc` into it on each step.

Top module: `mbj_next_pc`

## Requirements
- R1: `rs_idx` equals instruction bits 25:21 and `rt_idx` equals bits 20:16, both right-justified to bit 0.
- R2: With opcode (bits 31:26) 0x00 and function field (bits 5:0) 0x08, `next_pc` equals `rs_val`.
- R3: With opcode 0x03, `next_pc[27:0]` is the 26-bit index field (bits 25:0) shifted left by two, and `next_pc[31:28]` comes from `cur_pc + 4`.
- R4: With opcode 0x05, when `rs_val != rt_val`, `next_pc = cur_pc + 4 + (sign-extended bits 15:0) * 4`; otherwise `next_pc = cur_pc + 4`.
- R5: With opcode 0x06, when `rs_val` read as signed is zero or negative, `next_pc = cur_pc + 4 + (sign-extended bits 15:0) * 4`; otherwise `cur_pc + 4`. `rt_val` has no effect.
- R6: Every other opcode, and opcode 0x00 with any other function value, gives `next_pc = cur_pc + 4`.
- R7: `link_we` is high only for opcode 0x03; otherwise it is low and `link_data` is zero.
- R8: For opcode 0x03, `link_data` is `cur_pc + 8` when `delay_slot_en` is 1 and `cur_pc + 4` when it is 0.
- R9: A jump-and-link in the last word of a 256 MiB region takes its upper four bits from the next region, not from `cur_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | 32 | Address of the instruction being executed |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value read for the first source register |
| rt_val | input | 32 | Value read for the second source register |
| delay_slot_en | input | 1 | 1 when the architecture has a delay slot after jumps |
| rs_idx | output | 5 | First source register number |
| rt_idx | output | 5 | Second source register number |
| next_pc | output | 32 | Next fetch address |
| link_we | output | 1 | Write request for register 31 |
| link_data | output | 32 | Return address to write to register 31 |

## Verification
Every output is combinational, so it settles in the same cycle as its inputs. The bench drives inputs on a falling edge and samples one nanosecond later, well before the next rising edge. The bench's own program-counter register shows the effect of `next_pc` exactly one rising edge later. In the stepping test the bench therefore raises the step enable for one rising edge and reads the register at the falling edge that follows.

// File: rtl/mbj_pkg.sv
package mbj_pkg;
  localparam int OPC_W     = 6;
  localparam int REG_IDX_W = 5;
  localparam int IMM_W     = 16;
  localparam int JIDX_W    = 26;
  localparam int OPC_LSB   = 26;
  localparam int RS_LSB    = 21;
  localparam int RT_LSB    = 16;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JAL     = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BNE     = 6'h05;
  localparam logic [OPC_W-1:0] OPC_BLEZ    = 6'h06;
  localparam logic [OPC_W-1:0] FN_JR       = 6'h08;

  typedef enum logic [2:0] {
    K_SEQ,
    K_JR,
    K_JAL,
    K_BNE,
    K_BLEZ
  } ctl_kind_e;
endpackage

// File: rtl/mbj_decode.sv
module mbj_decode
  import mbj_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]         instr,
  output ctl_kind_e            kind,
  output logic [REG_IDX_W-1:0] rs_idx,
  output logic [REG_IDX_W-1:0] rt_idx,
  output logic [IMM_W-1:0]     imm,
  output logic [JIDX_W-1:0]    jidx
);
  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] fn;

  always_comb begin
    opc    = instr[OPC_LSB +: OPC_W];
    fn     = instr[OPC_W-1:0];
    rs_idx = instr[RS_LSB +: REG_IDX_W];
    rt_idx = instr[RT_LSB +: REG_IDX_W];
    imm    = instr[IMM_W-1:0];
    jidx   = instr[JIDX_W-1:0];
  end

  always_comb begin
    kind = K_SEQ;
    unique case (opc)
      OPC_SPECIAL: if (fn == FN_JR) kind = K_JR;
      OPC_JAL:     kind = K_JAL;
      OPC_BNE:     kind = K_BNE;
      OPC_BLEZ:    kind = K_BLEZ;
      default:     kind = K_SEQ;
    endcase
  end
endmodule

// File: rtl/mbj_cond.sv
module mbj_cond
  import mbj_pkg::*;
#(
  parameter int W = 32
) (
  input  ctl_kind_e    kind,
  input  logic [W-1:0] rs_val,
  input  logic [W-1:0] rt_val,
  output logic         taken
);
  logic differ;
  logic le_zero;

  always_comb begin
    differ  = (rs_val != rt_val);
    le_zero = rs_val[W-1] | (rs_val == '0);
    case (kind)
      K_BNE:   taken = differ;
      K_BLEZ:  taken = le_zero;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/mbj_target.sv
module mbj_target
  import mbj_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      cur_pc,
  input  ctl_kind_e         kind,
  input  logic              taken,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JIDX_W-1:0] jidx,
  input  logic [W-1:0]      rs_val,
  output logic [W-1:0]      pc_plus4,
  output logic [W-1:0]      pc_plus8,
  output logic [W-1:0]      next_pc
);
  localparam int JLOW_W = JIDX_W + 2;
  localparam int EXT_W  = W - IMM_W - 2;
  localparam logic [W-1:0] WORD  = W'(4);
  localparam logic [W-1:0] DWORD = W'(8);

  logic [W-1:0] br_off;
  logic [W-1:0] br_tgt;
  logic [W-1:0] jmp_tgt;

  always_comb begin
    pc_plus4 = cur_pc + WORD;
    pc_plus8 = cur_pc + DWORD;
    br_off   = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    br_tgt   = pc_plus4 + br_off;
    jmp_tgt  = {pc_plus4[W-1:JLOW_W], jidx, 2'b00};
  end

  always_comb begin
    case (kind)
      K_JR:           next_pc = rs_val;
      K_JAL:          next_pc = jmp_tgt;
      K_BNE, K_BLEZ:  next_pc = taken ? br_tgt : pc_plus4;
      default:        next_pc = pc_plus4;
    endcase
  end
endmodule

// File: rtl/mbj_next_pc.sv
module mbj_next_pc
  import mbj_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [31:0] cur_pc,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  input  logic        delay_slot_en,
  output logic [4:0]  rs_idx,
  output logic [4:0]  rt_idx,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [31:0] link_data
);
  ctl_kind_e          kind;
  logic [IMM_W-1:0]   imm;
  logic [JIDX_W-1:0]  jidx;
  logic               taken;
  logic [W-1:0]       pc_plus4;
  logic [W-1:0]       pc_plus8;

  mbj_decode #(.W(W)) u_dec (
    .instr  (instr),
    .kind   (kind),
    .rs_idx (rs_idx),
    .rt_idx (rt_idx),
    .imm    (imm),
    .jidx   (jidx)
  );

  mbj_cond #(.W(W)) u_cond (
    .kind   (kind),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .taken  (taken)
  );

  mbj_target #(.W(W)) u_tgt (
    .cur_pc   (cur_pc),
    .kind     (kind),
    .taken    (taken),
    .imm      (imm),
    .jidx     (jidx),
    .rs_val   (rs_val),
    .pc_plus4 (pc_plus4),
    .pc_plus8 (pc_plus8),
    .next_pc  (next_pc)
  );

  always_comb begin
    link_we   = (kind == K_JAL);
    link_data = '0;
    if (link_we) link_data = delay_slot_en ? pc_plus8 : pc_plus4;
  end
endmodule

// File: rtl/mbj_checker.sv
module mbj_checker (
  input logic [31:0] cur_pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        delay_slot_en,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic [31:0] link_data
);
  logic [5:0]  opc;
  logic [31:0] seq;
  logic        known;

  always_comb begin
    opc   = instr[31:26];
    seq   = cur_pc + 32'd4;
    known = !$isunknown({cur_pc, instr, rs_val, rt_val, delay_slot_en,
                         next_pc, link_we, link_data});
    if (known) begin
      a_r2_jr_target: assert (!(opc == 6'h00 && instr[5:0] == 6'h08) || next_pc == rs_val)
        else $error("R2 indirect jump target");
      a_r3_jal_low: assert (!link_we || next_pc[27:0] == {instr[25:0], 2'b00})
        else $error("R3 jump low bits");
      a_r9_jal_region: assert (!link_we || next_pc[31:28] == seq[31:28])
        else $error("R9 jump region bits");
      a_r4_bne_equal: assert (!(opc == 6'h05 && rs_val == rt_val) || next_pc == seq)
        else $error("R4 equal operands must fall through");
      a_r5_blez_positive: assert (!(opc == 6'h06 && !rs_val[31] && rs_val != 0) || next_pc == seq)
        else $error("R5 positive operand must fall through");
      a_r6_seq: assert (!(opc != 6'h00 && opc != 6'h03 && opc != 6'h05 && opc != 6'h06) || next_pc == seq)
        else $error("R6 sequential flow");
      a_r7_link_only_jal: assert (!link_we || opc == 6'h03)
        else $error("R7 link write outside jump-and-link");
      a_r7_link_zero: assert (link_we || link_data == 32'd0)
        else $error("R7 link data not zero");
      a_r8_link_value: assert (!link_we || link_data == (delay_slot_en ? cur_pc + 32'd8 : seq))
        else $error("R8 link value");
    end
  end
endmodule

bind mbj_next_pc mbj_checker u_chk (
  .cur_pc        (cur_pc),
  .instr         (instr),
  .rs_val        (rs_val),
  .rt_val        (rt_val),
  .delay_slot_en (delay_slot_en),
  .next_pc       (next_pc),
  .link_we       (link_we),
  .link_data     (link_data)
);

// File: tb/mbj_next_pc_tb.sv
`timescale 1ns/1ps
module mbj_next_pc_tb;
  localparam logic [31:0] TEXT_BASE = 32'h0040_0000;

  logic        clk;
  logic        rst_n;
  logic [31:0] pc_drv;
  logic [31:0] pc_q;
  logic        run_mode;
  logic        step_en;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic        delay_slot_en;
  logic [4:0]  rs_idx;
  logic [4:0]  rt_idx;
  logic [31:0] next_pc;
  logic        link_we;
  logic [31:0] link_data;
  logic [31:0] cur_pc;

  int n_chk;
  int n_bad;

  assign cur_pc = run_mode ? pc_q : pc_drv;

  mbj_next_pc u_dut (
    .cur_pc        (cur_pc),
    .instr         (instr),
    .rs_val        (rs_val),
    .rt_val        (rt_val),
    .delay_slot_en (delay_slot_en),
    .rs_idx        (rs_idx),
    .rt_idx        (rt_idx),
    .next_pc       (next_pc),
    .link_we       (link_we),
    .link_data     (link_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= TEXT_BASE;
    else if (step_en) pc_q <= next_pc;
  end

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b, input logic ds);
    @(negedge clk);
    pc_drv = pc; instr = ins; rs_val = a; rt_val = b; delay_slot_en = ds;
    #1;
  endtask

  task automatic t_reset;
    check("R6 reset pc", pc_q, TEXT_BASE);
  endtask

  task automatic t_fields;
    apply(TEXT_BASE, enc_r(5'd26, 5'd5, 5'd9, 6'h20), 32'd0, 32'd0, 1'b0);
    check("R1 rs index", {27'd0, rs_idx}, 32'd26);
    check("R1 rt index", {27'd0, rt_idx}, 32'd5);
  endtask

  task automatic t_jr;
    apply(32'h0040_0020, enc_r(5'd31, 5'd0, 5'd0, 6'h08), 32'h7FFF_0010, 32'h1, 1'b1);
    check("R2 jr target", next_pc, 32'h7FFF_0010);
    check("R7 jr no link", {31'd0, link_we}, 32'd0);
    check("R7 jr link data", link_data, 32'd0);
  endtask

  task automatic t_jal;
    apply(TEXT_BASE, enc_j(6'h03, 26'h010_0040), 32'd0, 32'd0, 1'b0);
    check("R3 jal target", next_pc, 32'h0040_0100);
    check("R7 jal link we", {31'd0, link_we}, 32'd1);
    check("R8 link no slot", link_data, 32'h0040_0004);
    apply(TEXT_BASE, enc_j(6'h03, 26'h010_0040), 32'd0, 32'd0, 1'b1);
    check("R8 link with slot", link_data, 32'h0040_0008);
  endtask

  task automatic t_region;
    apply(32'h0FFF_FFFC, enc_j(6'h03, 26'h000_0010), 32'd0, 32'd0, 1'b1);
    check("R9 region target", next_pc, 32'h1000_0040);
    check("R9 region link", link_data, 32'h1000_0004);
  endtask

  task automatic t_bne;
    apply(32'h0040_0010, enc_i(6'h05, 5'd1, 5'd2, 16'h0003), 32'd5, 32'd7, 1'b0);
    check("R4 bne forward", next_pc, 32'h0040_0020);
    check("R7 bne no link", {31'd0, link_we}, 32'd0);
    apply(32'h0040_0010, enc_i(6'h05, 5'd1, 5'd2, 16'hFFFF), 32'd5, 32'd7, 1'b0);
    check("R4 bne backward", next_pc, 32'h0040_0010);
    apply(32'h0040_0010, enc_i(6'h05, 5'd1, 5'd2, 16'h0003), 32'd7, 32'd7, 1'b0);
    check("R4 bne not taken", next_pc, 32'h0040_0014);
  endtask

  task automatic t_blez;
    apply(32'h0040_0100, enc_i(6'h06, 5'd3, 5'd0, 16'h0010), 32'd0, 32'd0, 1'b0);
    check("R5 blez zero", next_pc, 32'h0040_0144);
    apply(32'h0040_0100, enc_i(6'h06, 5'd3, 5'd0, 16'hFFF0), 32'h8000_0000, 32'd0, 1'b0);
    check("R5 blez negative", next_pc, 32'h0040_00C4);
    apply(32'h0040_0100, enc_i(6'h06, 5'd3, 5'd0, 16'h0010), 32'd1, 32'd0, 1'b0);
    check("R5 blez positive", next_pc, 32'h0040_0104);
    apply(32'h0040_0100, enc_i(6'h06, 5'd3, 5'd7, 16'h0010), 32'd0, 32'hFFFF_FFFF, 1'b0);
    check("R5 blez rt ignored", next_pc, 32'h0040_0144);
  endtask

  task automatic t_seq;
    apply(32'h0040_0200, enc_i(6'h08, 5'd1, 5'd2, 16'hFFFF), 32'd1, 32'd2, 1'b1);
    check("R6 addi sequential", next_pc, 32'h0040_0204);
    check("R7 addi no link", {31'd0, link_we}, 32'd0);
    apply(32'h0040_0200, enc_r(5'd1, 5'd2, 5'd3, 6'h20), 32'd1, 32'd2, 1'b0);
    check("R6 r-type sequential", next_pc, 32'h0040_0204);
    apply(32'h0040_0200, enc_i(6'h04, 5'd1, 5'd2, 16'h0008), 32'd1, 32'd1, 1'b0);
    check("R6 other branch opcode", next_pc, 32'h0040_0204);
  endtask

  task automatic t_run;
    @(negedge clk);
    run_mode = 1'b1;
    instr = enc_j(6'h03, 26'h010_0040); rs_val = 32'd0; rt_val = 32'd0; delay_slot_en = 1'b0;
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    check("R3 stepped jal pc", pc_q, 32'h0040_0100);
    instr = enc_r(5'd31, 5'd0, 5'd0, 6'h08); rs_val = 32'h0040_0004;
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    check("R2 stepped jr pc", pc_q, 32'h0040_0004);
    run_mode = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    run_mode = 1'b0; step_en = 1'b0;
    pc_drv = TEXT_BASE; instr = 32'd0; rs_val = 32'd0; rt_val = 32'd0; delay_slot_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_fields;
    t_jr;
    t_jal;
    t_region;
    t_bne;
    t_blez;
    t_seq;
    t_run;
    finish_run;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule